// File: doc/BRIEF.md
# Pattern Bank Extender with Soft-Reset Indicator

This block sits next to a standard scanline-counting bank controller on an 8-bit console cartridge. It adds one byte-wide extension register at a single CPU address. It also keeps a read-only indicator byte that flips on every soft reset, so software can tell a warm restart from a cold one.

On the pattern bus the inner controller supplies an 8-bit number for each 1 KiB bank. The extender widens it to a 9-bit index. The ninth bit comes from one extension bit, and which bit depends on the 2 KiB quadrant the pattern address falls in. The index is then masked to the number of bank bits the fitted ROM needs. A separate extension bit takes the whole 8 KiB pattern window away from ROM and gives it to on-board RAM for both reads and writes.

The inner controller's own registers, scanline interrupt and program banking stay outside this block. All CPU addresses other than the extension address are left to it.

Top module: `patbank_ext`

## Requirements
- R1: When rst_n is low at a clock edge, the extension register and the indicator byte both become 0x00. A CPU read of 0x4100 afterwards returns 0x00.
- R2: A CPU write at exactly address 0x4100 loads the whole written byte into the extension register at the next clock edge. Writes at any other address leave it unchanged.
- R3: While cpu_rd is high and cpu_addr is 0x4100, cpu_rdata_en is 1 and cpu_rdata shows the indicator byte, never the extension register. At any other time cpu_rdata_en is 0 and cpu_rdata is 0x00.
- R4: Each clock edge with soft_rst high inverts all eight indicator bits (0x00 and 0xFF alternate) and clears the extension register. A soft reset takes priority over a write in the same cycle, and such a write does not touch the indicator.
- R5: While extension bit 6 is 1 (RAM mode), ram_addr equals pat_addr[12:0], ram_rd_en follows pat_rd, ram_wr_en follows pat_wr and rom_rd_en is 0. The inner bank number has no effect.
- R6: While extension bit 6 is 0 (ROM mode), rom_offset equals pat_addr[9:0] and rom_rd_en follows pat_rd. The 9-bit index has the inner bank number in bits 7:0 and the outer bit in bit 8.
- R7: The outer bit is selected by pat_addr[12:11]. Quadrant 0 uses extension bit 3, quadrant 1 uses bit 2, quadrant 2 uses bit 0 and quadrant 3 uses bit 1.
- R8: In ROM mode ram_rd_en and ram_wr_en are 0. A pattern write changes neither the extension register nor the indicator.
- R9: rom_bank is the 9-bit index masked to its ROM_BANK_BITS low bits. With ROM_BANK_BITS = 8 the outer bit never reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| soft_rst | input | 1 | Soft reset; each high cycle counts as one event |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | Read data for the extension address |
| cpu_rdata_en | output | 1 | Block is driving cpu_rdata |
| pat_addr | input | 13 | Pattern-bus address within the 8 KiB window |
| pat_rd | input | 1 | Pattern read strobe |
| pat_wr | input | 1 | Pattern write strobe |
| inner_bank | input | 8 | 1 KiB bank number from the inner controller |
| rom_bank | output | ROM_BANK_BITS | Masked 1 KiB ROM bank index |
| rom_offset | output | 10 | Byte offset within the 1 KiB bank |
| rom_rd_en | output | 1 | Pattern ROM read enable |
| ram_addr | output | 13 | Pattern RAM address |
| ram_rd_en | output | 1 | Pattern RAM read enable |
| ram_wr_en | output | 1 | Pattern RAM write enable |

## Verification
The bench builds two copies side by side on the same stimulus. One uses the default ROM_BANK_BITS = 9, so every quadrant-to-bit mapping can be seen in bank bit 8. The other uses ROM_BANK_BITS = 8, which covers the masking path where the outer bit must vanish, as it would for a 256-bank ROM. The random CPU addresses are weighted toward 0x4100 and its immediate neighbours, so the decode boundaries are hit often. Soft resets are mixed in so that the indicator alternates many times and sometimes coincides with a write.

// File: rtl/patbank_ext_pkg.sv
// Package: shared constants and helpers for the pattern bank extender.
// Assumes an 8-bit data bus and a 16-bit CPU address space.
package patbank_ext_pkg;

    localparam int DATA_W       = 8;
    localparam int CPU_AW       = 16;
    localparam int PAT_AW       = 13;
    localparam int INNER_W      = 8;
    localparam int OFF_W        = 10;
    localparam int FULL_BANK_W  = INNER_W + 1;
    localparam int QUADS        = 4;

    localparam logic [CPU_AW-1:0] EXT_REG_ADDR = 16'h4100;
    localparam int RAM_MODE_BIT = 6;

    // Quadrant of the pattern window, taken from the top two address bits.
    typedef enum logic [1:0] {
        QUAD_LO0 = 2'd0,
        QUAD_LO1 = 2'd1,
        QUAD_HI0 = 2'd2,
        QUAD_HI1 = 2'd3
    } quad_e;

    // Extension-register bit that supplies the outer bank bit for a quadrant.
    function automatic int outer_src_bit(input int quad);
        case (quad)
            0:       return 3;
            1:       return 2;
            2:       return 0;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/ext_cpu_regs.sv
// Module: ext_cpu_regs
// Holds the extension register and the soft-reset indicator byte and
// decodes CPU accesses to the single extension address.
// Assumes: soft_rst is sampled every clock, and each high cycle is one event.
module ext_cpu_regs
    import patbank_ext_pkg::*;
#(
    parameter logic [CPU_AW-1:0] EXT_ADDR = EXT_REG_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] ext_q,
    output logic [DATA_W-1:0] ind_q,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rdata_en
);

    logic addr_hit;

    // Exact match on the extension address.
    always_comb addr_hit = (cpu_addr == EXT_ADDR);

    // Extension register: cleared by either reset, loaded by a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ext_q <= '0;
        else if (soft_rst)           ext_q <= '0;
        else if (addr_hit && cpu_wr) ext_q <= cpu_wdata;
    end

    // Indicator byte: zero at power-on, every bit flips on each soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        ind_q <= '0;
        else if (soft_rst) ind_q <= ~ind_q;
    end

    // Read path: drive the indicator only while the extension address is read.
    always_comb begin
        cpu_rdata_en = addr_hit && cpu_rd;
        cpu_rdata    = cpu_rdata_en ? ind_q : '0;
    end

    // R2: a matching write without soft reset lands in the register.
    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == EXT_ADDR && !soft_rst) |=> ext_q == $past(cpu_wdata));

    // R2: writes elsewhere leave the register unchanged.
    a_r2_other_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !(cpu_wr && cpu_addr == EXT_ADDR)) |=> $stable(ext_q));

    // R4: soft reset clears the register and inverts the indicator.
    a_r4_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ext_q == '0) && (ind_q == ~$past(ind_q)));

    // R4: without soft reset the indicator holds.
    a_r4_indicator_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> $stable(ind_q));

    // R4: indicator is only ever all-zeros or all-ones.
    a_r4_indicator_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_q == '0) || (ind_q == '1));

endmodule

// File: rtl/ext_outer_select.sv
// Module: ext_outer_select
// Picks the outer bank bit from the extension register by pattern quadrant.
// Assumes four quadrants whose source bits come from outer_src_bit().
module ext_outer_select
    import patbank_ext_pkg::*;
(
    input  logic [DATA_W-1:0] ext_q,
    input  quad_e             quad,
    output logic              outer_bit
);

    logic [QUADS-1:0] cand;

    // One candidate per quadrant, each wired to its source extension bit.
    for (genvar q = 0; q < QUADS; q++) begin : g_quad
        localparam int SRC = outer_src_bit(q);
        assign cand[q] = ext_q[SRC];
    end

    // Select the candidate for the current quadrant.
    always_comb outer_bit = cand[quad];

endmodule

// File: rtl/ext_pattern_steer.sv
// Module: ext_pattern_steer
// Steers a pattern access to ROM (widened, masked bank index) or to RAM.
// Assumes ROM_BANK_BITS is between 1 and FULL_BANK_W.
module ext_pattern_steer
    import patbank_ext_pkg::*;
#(
    parameter int ROM_BANK_BITS = FULL_BANK_W
) (
    input  logic                     ram_mode,
    input  logic [PAT_AW-1:0]        pat_addr,
    input  logic                     pat_rd,
    input  logic                     pat_wr,
    input  logic [INNER_W-1:0]       inner_bank,
    input  logic                     outer_bit,
    output logic [ROM_BANK_BITS-1:0] rom_bank,
    output logic [OFF_W-1:0]         rom_offset,
    output logic                     rom_rd_en,
    output logic [PAT_AW-1:0]        ram_addr,
    output logic                     ram_rd_en,
    output logic                     ram_wr_en
);

    logic [FULL_BANK_W-1:0] full_idx;

    // Widen the inner bank number with the outer bit on top.
    always_comb full_idx = {outer_bit, inner_bank};

    // ROM side: masked index, in-bank offset, read only outside RAM mode.
    always_comb begin
        rom_bank   = full_idx[ROM_BANK_BITS-1:0];
        rom_offset = pat_addr[OFF_W-1:0];
        rom_rd_en  = pat_rd && !ram_mode;
    end

    // RAM side: flat 8 KiB window, both strobes only in RAM mode.
    always_comb begin
        ram_addr  = pat_addr;
        ram_rd_en = pat_rd && ram_mode;
        ram_wr_en = pat_wr && ram_mode;
    end

endmodule

// File: rtl/patbank_ext.sv
// Module: patbank_ext (top)
// Extension latch beside a scanline-counting bank controller: the extension
// register, the soft-reset indicator, quadrant-based outer bank bit and the
// ROM/RAM steering of the pattern window.
// Assumes synchronous active-low power-on reset; soft_rst is a separate input.
module patbank_ext
    import patbank_ext_pkg::*;
#(
    parameter int                ROM_BANK_BITS = FULL_BANK_W,
    parameter logic [CPU_AW-1:0] EXT_ADDR      = EXT_REG_ADDR
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_rst,
    input  logic [15:0]              cpu_addr,
    input  logic [7:0]               cpu_wdata,
    input  logic                     cpu_wr,
    input  logic                     cpu_rd,
    output logic [7:0]               cpu_rdata,
    output logic                     cpu_rdata_en,
    input  logic [12:0]              pat_addr,
    input  logic                     pat_rd,
    input  logic                     pat_wr,
    input  logic [7:0]               inner_bank,
    output logic [ROM_BANK_BITS-1:0] rom_bank,
    output logic [9:0]               rom_offset,
    output logic                     rom_rd_en,
    output logic [12:0]              ram_addr,
    output logic                     ram_rd_en,
    output logic                     ram_wr_en
);

    logic [DATA_W-1:0] ext_q;
    logic [DATA_W-1:0] ind_q;
    logic              outer_bit;
    logic              ram_mode;
    quad_e             quad;

    // Mode and quadrant decode from register and pattern address.
    always_comb begin
        ram_mode = ext_q[RAM_MODE_BIT];
        quad     = quad_e'(pat_addr[PAT_AW-1:PAT_AW-2]);
    end

    ext_cpu_regs #(.EXT_ADDR(EXT_ADDR)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_wr       (cpu_wr),
        .cpu_rd       (cpu_rd),
        .ext_q        (ext_q),
        .ind_q        (ind_q),
        .cpu_rdata    (cpu_rdata),
        .cpu_rdata_en (cpu_rdata_en)
    );

    ext_outer_select u_outer (
        .ext_q     (ext_q),
        .quad      (quad),
        .outer_bit (outer_bit)
    );

    ext_pattern_steer #(.ROM_BANK_BITS(ROM_BANK_BITS)) u_steer (
        .ram_mode   (ram_mode),
        .pat_addr   (pat_addr),
        .pat_rd     (pat_rd),
        .pat_wr     (pat_wr),
        .inner_bank (inner_bank),
        .outer_bit  (outer_bit),
        .rom_bank   (rom_bank),
        .rom_offset (rom_offset),
        .rom_rd_en  (rom_rd_en),
        .ram_addr   (ram_addr),
        .ram_rd_en  (ram_rd_en),
        .ram_wr_en  (ram_wr_en)
    );

    // R5: ROM and RAM never both take a read.
    a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_rd_en && ram_rd_en));

    // R8: a pattern write in ROM mode never reaches the RAM.
    a_r8_rom_mode_no_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_wr && !ext_q[RAM_MODE_BIT]) |-> !ram_wr_en);

    // R3: read data is quiet unless the block is selected.
    a_r3_quiet_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rdata_en |-> (cpu_rdata == '0));

    // R7: with the full width, bank bit 8 tracks the quadrant's source bit.
    if (ROM_BANK_BITS == FULL_BANK_W) begin : g_outer_chk
        a_r7_outer_bit_source: assert property (@(posedge clk) disable iff (!rst_n)
            (pat_rd && !ext_q[RAM_MODE_BIT]) |->
            ((pat_addr[12:11] == 2'd0 && rom_bank[8] == ext_q[3]) ||
             (pat_addr[12:11] == 2'd1 && rom_bank[8] == ext_q[2]) ||
             (pat_addr[12:11] == 2'd2 && rom_bank[8] == ext_q[0]) ||
             (pat_addr[12:11] == 2'd3 && rom_bank[8] == ext_q[1])));
    end

endmodule

// File: tb/patbank_ext_tb.sv
module patbank_ext_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [12:0] pat_addr = '0;
    logic        pat_rd = 1'b0;
    logic        pat_wr = 1'b0;
    logic [7:0]  inner_bank = '0;

    logic [7:0]  cpu_rdata, cpu_rdata_b;
    logic        cpu_rdata_en, cpu_rdata_en_b;
    logic [8:0]  rom_bank;
    logic [7:0]  rom_bank_b;
    logic [9:0]  rom_offset, rom_offset_b;
    logic        rom_rd_en, rom_rd_en_b;
    logic [12:0] ram_addr, ram_addr_b;
    logic        ram_rd_en, ram_rd_en_b, ram_wr_en, ram_wr_en_b;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          finished = 1'b0;

    logic [7:0]  ext_m = '0;
    logic [7:0]  ind_m = '0;

    always #4 clk = ~clk;

    patbank_ext u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_rdata(cpu_rdata), .cpu_rdata_en(cpu_rdata_en),
        .pat_addr(pat_addr), .pat_rd(pat_rd), .pat_wr(pat_wr), .inner_bank(inner_bank),
        .rom_bank(rom_bank), .rom_offset(rom_offset), .rom_rd_en(rom_rd_en),
        .ram_addr(ram_addr), .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en)
    );

    patbank_ext #(.ROM_BANK_BITS(8)) u_dut_narrow (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_rdata(cpu_rdata_b), .cpu_rdata_en(cpu_rdata_en_b),
        .pat_addr(pat_addr), .pat_rd(pat_rd), .pat_wr(pat_wr), .inner_bank(inner_bank),
        .rom_bank(rom_bank_b), .rom_offset(rom_offset_b), .rom_rd_en(rom_rd_en_b),
        .ram_addr(ram_addr_b), .ram_rd_en(ram_rd_en_b), .ram_wr_en(ram_wr_en_b)
    );

    // Expected 9-bit index from the quadrant rule (R6, R7).
    function automatic logic [8:0] exp_index(input logic [7:0] ext, input logic [7:0] inner,
                                             input logic [12:0] a);
        logic ob;
        case (a[12:11])
            2'd0: ob = ext[3];
            2'd1: ob = ext[2];
            2'd2: ob = ext[0];
            default: ob = ext[1];
        endcase
        return {ob, inner};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all combinational outputs against the model state.
    task automatic check_outputs();
        logic sel;
        logic [8:0] idx;
        sel = cpu_rd && (cpu_addr == 16'h4100);
        chk("R3 rdata_en", {31'd0, cpu_rdata_en}, {31'd0, sel});
        chk("R3 rdata", {24'd0, cpu_rdata}, sel ? {24'd0, ind_m} : 32'd0);
        chk("R3 rdata narrow", {24'd0, cpu_rdata_b}, sel ? {24'd0, ind_m} : 32'd0);
        if (ext_m[6]) begin
            chk("R5 ram_addr", {19'd0, ram_addr}, {19'd0, pat_addr});
            chk("R5 ram_rd_en", {31'd0, ram_rd_en}, {31'd0, pat_rd});
            chk("R5 ram_wr_en", {31'd0, ram_wr_en}, {31'd0, pat_wr});
            chk("R5 rom_rd_en", {31'd0, rom_rd_en}, 32'd0);
        end else begin
            idx = exp_index(ext_m, inner_bank, pat_addr);
            chk("R7 rom_bank", {23'd0, rom_bank}, {23'd0, idx});
            chk("R6 rom_offset", {22'd0, rom_offset}, {22'd0, pat_addr[9:0]});
            chk("R6 rom_rd_en", {31'd0, rom_rd_en}, {31'd0, pat_rd});
            chk("R8 ram_rd_en", {31'd0, ram_rd_en}, 32'd0);
            chk("R8 ram_wr_en", {31'd0, ram_wr_en}, 32'd0);
            chk("R9 rom_bank narrow", {24'd0, rom_bank_b}, {24'd0, idx[7:0]});
        end
    endtask

    // Drive one cycle of stimulus, check, then advance the model past the edge.
    task automatic step(input logic [15:0] a, input logic [7:0] d, input logic wr,
                        input logic rd, input logic sr, input logic [12:0] pa,
                        input logic prd, input logic pwr, input logic [7:0] ib);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = wr; cpu_rd = rd; soft_rst = sr;
        pat_addr = pa; pat_rd = prd; pat_wr = pwr; inner_bank = ib;
        #1;
        check_outputs();
        @(posedge clk);
        if (sr) begin
            ext_m = 8'h00;
            ind_m = ~ind_m;
        end else if (wr && a == 16'h4100) begin
            ext_m = d;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5EED_0262);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, indicator reads 0, ROM mode with zero outer bit.
        step(16'h4100, 8'h00, 1'b0, 1'b1, 1'b0, 13'h0000, 1'b1, 1'b0, 8'h00);
        step(16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 13'h1FFF, 1'b1, 1'b0, 8'h5A);

        // R2: neighbouring addresses do not load the register.
        step(16'h4101, 8'h4F, 1'b1, 1'b0, 1'b0, 13'h0000, 1'b0, 1'b0, 8'h00);
        step(16'h40FF, 8'h4F, 1'b1, 1'b0, 1'b0, 13'h0000, 1'b1, 1'b1, 8'h11);
        // R2, R7: each quadrant's source bit alone.
        step(16'h4100, 8'h08, 1'b1, 1'b0, 1'b0, 13'h0000, 1'b0, 1'b0, 8'h00);
        step(16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 13'h0000, 1'b1, 1'b0, 8'h00);
        step(16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 13'h0800, 1'b1, 1'b0, 8'h00);
        step(16'h4100, 8'h04, 1'b1, 1'b0, 1'b0, 13'h0BFF, 1'b1, 1'b0, 8'h00);
        step(16'h4100, 8'h01, 1'b1, 1'b0, 1'b0, 13'h0800, 1'b1, 1'b0, 8'h00);
        step(16'h4100, 8'h02, 1'b1, 1'b0, 1'b0, 13'h1000, 1'b1, 1'b0, 8'hFF);
        step(16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 13'h1800, 1'b1, 1'b0, 8'hFF);
        step(16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 13'h17FF, 1'b1, 1'b0, 8'hFF);

        // R5: RAM mode across the window; R3: read still shows indicator.
        step(16'h4100, 8'h4F, 1'b1, 1'b1, 1'b0, 13'h0000, 1'b0, 1'b0, 8'h00);
        step(16'h4100, 8'h00, 1'b0, 1'b1, 1'b0, 13'h0000, 1'b0, 1'b1, 8'h33);
        step(16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 13'h1FFF, 1'b1, 1'b0, 8'h33);

        // R4: soft reset wins over a simultaneous write, indicator flips.
        step(16'h4100, 8'hFF, 1'b1, 1'b0, 1'b1, 13'h0000, 1'b0, 1'b0, 8'h00);
        step(16'h4100, 8'h00, 1'b0, 1'b1, 1'b0, 13'h0000, 1'b1, 1'b1, 8'h00);
        step(16'h4100, 8'h00, 1'b0, 1'b1, 1'b1, 13'h0000, 1'b0, 1'b0, 8'h00);
        step(16'h4100, 8'h00, 1'b0, 1'b1, 1'b0, 13'h0000, 1'b0, 1'b0, 8'h00);

        // R8: ROM-mode pattern writes leave state intact (model unchanged).
        step(16'h4100, 8'h0F, 1'b1, 1'b0, 1'b0, 13'h0000, 1'b0, 1'b1, 8'h00);
        step(16'h4100, 8'h00, 1'b0, 1'b1, 1'b0, 13'h1C00, 1'b1, 1'b1, 8'h80);

        // Random mix weighted toward the extension address and its neighbours.
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [31:0] r;
            r = $urandom();
            case (r[1:0])
                2'd0, 2'd3: a = 16'h4100;
                2'd1:       a = r[2] ? 16'h4101 : 16'h40FF;
                default:    a = $urandom();
            endcase
            step(a, 8'($urandom()), ($urandom() % 3) == 0, r[3],
                 ($urandom() % 16) == 0, 13'($urandom()), r[4], r[5], 8'($urandom()));
        end

        summary();
    end

endmodule